// File: doc/BRIEF.md
# UART Prioritized Interrupt Identification

This block is the interrupt identification logic of one UART channel. Surrounding logic reports seven interrupt conditions: line status error, receive data ready, receive timeout, transmit holding empty, modem status change, Xoff or special-character match, and CTS/RTS change of state. Each condition is reported through a set pulse, and each has a clear pulse. The block keeps one pending flag per source and drives an interrupt output. When the CPU reads the status register, the block captures an 8-bit identification word that names only the highest-priority source that is pending.

Two of the sources, the Xoff match and the CTS/RTS change, exist only in enhanced mode. When the enhanced-feature flag is low, these two sources are masked. They can still be latched, but they are never reported and never raise the interrupt. The top two bits of the word show whether the FIFOs are enabled. Software services the reported source, then reads the register again to see the next source.

Top module: `uart_int_id`

## Requirements
- R1: After reset, statusOut is 0x01 and irqOut is 0.
- R2: Status bits [5:0] carry the code of the highest pending source. A line status error (srcSet bit 0) has priority 1 and code 000110, and it is reported whenever it is pending. A lower source shows only after the higher source is cleared and the register is read again.
- R3: Receive timeout (bit 2) and receive data ready (bit 1) share priority 2. The timeout code 001100 is reported when both are pending. Data ready alone reports 000100.
- R4: Transmit holding empty (bit 3) has priority 3 and code 000010. It is cleared by a status read that reports it, or by srcClr bit 3, which is a write to the transmit holding register.
- R5: Modem status change (bit 4) has priority 4 and code 000000.
- R6: When enhEn is 1, the Xoff/special-character source (bit 5, priority 5) reports 010000 and the CTS/RTS change source (bit 6, priority 6) reports 100000. When enhEn is 0, these two sources are never reported and do not assert irqOut.
- R7: Once the Xoff indication is set, it stays pending until srcClr bit 5 (Xon received) is pulsed. No status read clears it.
- R8: Status bits [7:6] read 11 when fifoEn is 1 at the read, and 00 when fifoEn is 0.
- R9: irqOut is 1 while any unmasked source is pending. It is 0 from the clock edge at which the last pending source clears. Bit 0 of a captured word is 0 when a source is pending and 1 when none is pending.
- R10: statusOut changes only at a clock edge where rdStb is 1. Sources that change between reads leave it unchanged.
- R11: When the set and clear of a source land at the same edge, the set wins and the source stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoEn | input | 1 | FIFO mode flag, shown in status bits [7:6] |
| enhEn | input | 1 | Enhanced-feature enable; unmasks sources 5 and 6 |
| srcSet | input | 7 | Per-source set pulses (0 line, 1 rx data, 2 timeout, 3 tx empty, 4 modem, 5 Xoff, 6 CTS/RTS) |
| srcClr | input | 7 | Per-source clear pulses; bit 3 is a transmit holding write, bit 5 is Xon received |
| rdStb | input | 1 | Status register read strobe |
| statusOut | output | 8 | Captured identification word |
| irqOut | output | 1 | Interrupt request, active high |

## Verification
The bench sets several sources together and checks that only the top-priority source is reported. A design with a wrong priority order would report a lower source. It also checks that the data-ready source does not hide a timeout. It checks that the two enhanced sources stay silent when enhEn is 0; a design that leaked them would raise irqOut and report code 010000 or 100000. It checks that a read clears the transmit-empty source and not the Xoff source, and that a set pulse landing on the same edge as a clear pulse keeps the source pending. Finally, it checks that statusOut does not follow the sources between reads; a design that exposed the live code there would show the new code without any read.

// File: rtl/uid_pkg.sv
package uid_pkg;
  localparam int NUM_SRC = 7;
  localparam int CODE_W  = 6;
  localparam int STAT_W  = 8;
  localparam int MODE_W  = STAT_W - CODE_W;

  localparam int SRC_LINE  = 0;
  localparam int SRC_RXRDY = 1;
  localparam int SRC_TMO   = 2;
  localparam int SRC_THRE  = 3;
  localparam int SRC_MODEM = 4;
  localparam int SRC_XOFF  = 5;
  localparam int SRC_FLOW  = 6;

  localparam logic [CODE_W-1:0] IDLE_CODE = 6'b000001;

  // strobes handed from control to datapath
  typedef struct packed {
    logic              capture;
    logic [CODE_W-1:0] code;
  } uid_strobe_t;

  // identification code per source; bit 0 low means pending
  function automatic logic [CODE_W-1:0] srcCode(input int idx);
    logic [CODE_W-1:0] c;
    case (idx)
      SRC_LINE:  c = 6'b000110;
      SRC_RXRDY: c = 6'b000100;
      SRC_TMO:   c = 6'b001100;
      SRC_THRE:  c = 6'b000010;
      SRC_MODEM: c = 6'b000000;
      SRC_XOFF:  c = 6'b010000;
      SRC_FLOW:  c = 6'b100000;
      default:   c = IDLE_CODE;
    endcase
    return c;
  endfunction

  // rank of a source, 0 is served first
  function automatic int srcRank(input int idx);
    int r;
    case (idx)
      SRC_LINE:  r = 0;
      SRC_TMO:   r = 1;
      SRC_RXRDY: r = 2;
      SRC_THRE:  r = 3;
      SRC_MODEM: r = 4;
      SRC_XOFF:  r = 5;
      default:   r = 6;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/uid_ctrl.sv
module uid_ctrl
  import uid_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               enhEn,
  input  logic [NUM_SRC-1:0] srcSet,
  input  logic [NUM_SRC-1:0] srcClr,
  input  logic               rdStb,
  output uid_strobe_t        strobe,
  output logic               irqOut
);
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] srcMask;
  logic [NUM_SRC-1:0] active;
  logic [NUM_SRC-1:0] clrVec;
  logic               anyActive;
  logic [CODE_W-1:0]  winCode;
  logic               winThre;
  logic               readClr;

  always_comb begin
    srcMask = '1;
    if (!enhEn) begin
      srcMask[SRC_XOFF] = 1'b0;
      srcMask[SRC_FLOW] = 1'b0;
    end
  end

  assign active    = pend & srcMask;
  assign anyActive = |active;

  // walk ranks from lowest to highest so the top pending source wins
  always_comb begin
    winCode = IDLE_CODE;
    winThre = 1'b0;
    for (int rk = NUM_SRC - 1; rk >= 0; rk--) begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if (srcRank(s) == rk && active[s]) begin
          winCode = srcCode(s);
          winThre = (s == SRC_THRE);
        end
      end
    end
  end

  assign readClr = rdStb && winThre;

  always_comb begin
    clrVec = srcClr;
    clrVec[SRC_THRE] = srcClr[SRC_THRE] | readClr;
  end

  // one sticky flag per source, set has priority over clear
  for (genvar g = 0; g < NUM_SRC; g++) begin : gPend
    always_ff @(posedge clk) begin
      if (!rstN) pend[g] <= 1'b0;
      else       pend[g] <= srcSet[g] | (pend[g] & ~clrVec[g]);
    end
  end

  assign strobe.capture = rdStb;
  assign strobe.code    = winCode;
  assign irqOut         = anyActive;

  AST_LINE_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && pend[SRC_LINE]) |-> (strobe.code == 6'b000110)); // R2

  AST_THRE_READCLR: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && strobe.code == 6'b000010 && !srcSet[SRC_THRE]) |=> !pend[SRC_THRE]); // R4

  AST_MASKED_ENH: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && !enhEn) |-> (strobe.code != 6'b010000 && strobe.code != 6'b100000)); // R6

  AST_XOFF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (pend[SRC_XOFF] && !srcClr[SRC_XOFF]) |=> pend[SRC_XOFF]); // R7

  AST_IDLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && !irqOut) |-> (strobe.code == IDLE_CODE)); // R9

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (|srcSet) |=> ((pend & $past(srcSet)) == $past(srcSet))); // R11
endmodule

// File: rtl/uid_dp.sv
module uid_dp
  import uid_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoEn,
  input  uid_strobe_t       strobe,
  output logic [STAT_W-1:0] statusOut
);
  logic [MODE_W-1:0] modeBits;

  assign modeBits = fifoEn ? {MODE_W{1'b1}} : {MODE_W{1'b0}};

  // word is frozen at the read so late source changes cannot tear it
  always_ff @(posedge clk) begin
    if (!rstN)               statusOut <= {{MODE_W{1'b0}}, IDLE_CODE};
    else if (strobe.capture) statusOut <= {modeBits, strobe.code};
  end

  AST_MODE_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    statusOut[STAT_W-1] == statusOut[STAT_W-2]); // R8

  AST_HOLD_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(statusOut)); // R10
endmodule

// File: rtl/uart_int_id.sv
module uart_int_id
  import uid_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               fifoEn,
  input  logic               enhEn,
  input  logic [NUM_SRC-1:0] srcSet,
  input  logic [NUM_SRC-1:0] srcClr,
  input  logic               rdStb,
  output logic [STAT_W-1:0]  statusOut,
  output logic               irqOut
);
  uid_strobe_t strobe;

  uid_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .enhEn  (enhEn),
    .srcSet (srcSet),
    .srcClr (srcClr),
    .rdStb  (rdStb),
    .strobe (strobe),
    .irqOut (irqOut)
  );

  uid_dp i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .fifoEn    (fifoEn),
    .strobe    (strobe),
    .statusOut (statusOut)
  );
endmodule

// File: tb/test_uart_int_id.sv
`timescale 1ns/1ps
module test_uart_int_id;
  logic       clk = 1'b0;
  logic       rstN;
  logic       fifoEn;
  logic       enhEn;
  logic [6:0] srcSet;
  logic [6:0] srcClr;
  logic       rdStb;
  logic [7:0] statusOut;
  logic       irqOut;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 1'b0;

  always #4 clk = ~clk;

  uart_int_id i_uart_int_id (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .enhEn(enhEn),
    .srcSet(srcSet), .srcClr(srcClr), .rdStb(rdStb),
    .statusOut(statusOut), .irqOut(irqOut)
  );

  // {set[6:0], enh, fifo, expStatus[7:0], expIrq, reqNum[3:0]}
  localparam int NV = 10;
  localparam logic [21:0] VEC [NV] = '{
    {7'h1B, 1'b1, 1'b1, 8'hC6, 1'b1, 4'd2},  // R2 line beats rx, thre, modem
    {7'h06, 1'b0, 1'b0, 8'h0C, 1'b1, 4'd3},  // R3 timeout over data ready
    {7'h02, 1'b0, 1'b1, 8'hC4, 1'b1, 4'd3},  // R3 data ready alone
    {7'h08, 1'b0, 1'b0, 8'h02, 1'b1, 4'd4},  // R4 tx empty
    {7'h70, 1'b1, 1'b0, 8'h00, 1'b1, 4'd5},  // R5 modem over enhanced
    {7'h60, 1'b1, 1'b0, 8'h10, 1'b1, 4'd6},  // R6 xoff over flow
    {7'h40, 1'b1, 1'b0, 8'h20, 1'b1, 4'd6},  // R6 flow alone
    {7'h60, 1'b0, 1'b1, 8'hC1, 1'b0, 4'd6},  // R6 masked when enh off
    {7'h00, 1'b0, 1'b1, 8'hC1, 1'b0, 4'd8},  // R8 idle with fifo on
    {7'h01, 1'b0, 1'b0, 8'h06, 1'b1, 4'd2}   // R2 line, legacy mode
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulseSet(input logic [6:0] v);
    srcSet = v;
    @(negedge clk);
    srcSet = '0;
  endtask

  task automatic pulseClr(input logic [6:0] v);
    srcClr = v;
    @(negedge clk);
    srcClr = '0;
  endtask

  task automatic doRead();
    rdStb = 1'b1;
    @(negedge clk);
    rdStb = 1'b0;
  endtask

  initial begin
    rstN = 1'b0; fifoEn = 1'b0; enhEn = 1'b0;
    srcSet = '0; srcClr = '0; rdStb = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 status", statusOut, 8'h01);
    chk("R1 irq", {7'b0, irqOut}, 8'h00);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      pulseClr(7'h7F);
      enhEn  = VEC[i][14];
      fifoEn = VEC[i][13];
      pulseSet(VEC[i][21:15]);
      chk($sformatf("R%0d vec%0d irq", VEC[i][3:0], i), {7'b0, irqOut}, {7'b0, VEC[i][4]});
      doRead();
      chk($sformatf("R%0d vec%0d status", VEC[i][3:0], i), statusOut, VEC[i][12:5]);
    end

    // R4 read that reports tx empty clears it
    pulseClr(7'h7F); enhEn = 1'b0; fifoEn = 1'b0;
    pulseSet(7'h08);
    doRead();
    chk("R4 first read", statusOut, 8'h02);
    chk("R4 irq after read clear", {7'b0, irqOut}, 8'h00);
    doRead();
    chk("R4 second read", statusOut, 8'h01);

    // R4 transmit holding write clears it
    pulseSet(7'h08);
    pulseClr(7'h08);
    chk("R4 irq after write", {7'b0, irqOut}, 8'h00);
    doRead();
    chk("R4 read after write", statusOut, 8'h01);

    // R2 lower source visible after service and re-read
    pulseSet(7'h03);
    doRead();
    chk("R2 top first", statusOut, 8'h06);
    pulseClr(7'h01);
    doRead();
    chk("R2 next after service", statusOut, 8'h04);

    // R9 irq drops at the edge the last source clears
    pulseClr(7'h02);
    chk("R9 irq dropped", {7'b0, irqOut}, 8'h00);
    doRead();
    chk("R9 idle word", statusOut, 8'h01);

    // R7 xoff survives reads and other clears until xon
    enhEn = 1'b1;
    pulseSet(7'h20);
    pulseClr(7'h5F);
    doRead();
    chk("R7 xoff held", statusOut, 8'h10);
    doRead();
    chk("R7 xoff after reread", statusOut, 8'h10);
    pulseClr(7'h20);
    chk("R7 irq after xon", {7'b0, irqOut}, 8'h00);
    doRead();
    chk("R7 cleared by xon", statusOut, 8'h01);
    enhEn = 1'b0;

    // R10 word frozen between reads
    pulseSet(7'h01);
    repeat (3) @(negedge clk);
    chk("R10 no read no change", statusOut, 8'h01);
    doRead();
    chk("R10 read captures", statusOut, 8'h06);
    pulseClr(7'h01);
    pulseSet(7'h10);
    fifoEn = 1'b1;
    @(negedge clk);
    chk("R10 hold after change", statusOut, 8'h06);
    doRead();
    chk("R8 fifo bits on read", statusOut, 8'hC0);

    // R11 set and clear on the same edge
    pulseClr(7'h7F);
    fifoEn = 1'b0;
    srcSet = 7'h02; srcClr = 7'h02;
    @(negedge clk);
    srcSet = '0; srcClr = '0;
    chk("R11 irq kept", {7'b0, irqOut}, 8'h01);
    doRead();
    chk("R11 set wins", statusOut, 8'h04);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule